// File: doc/BRIEF.md
# Indexed configuration register file

This block is a bank of 8-bit configuration registers reached through a two-step port. The host first pulses `idx_wr` with an 8-bit register index on `wdata`. The very next data access (`dat_wr` or `dat_rd`) targets that index, and the index is then spent. The bank holds six control registers, eight 24-bit address-range registers stored as three bytes each, eight region attribute registers and two read-only identification bytes.

Part of the index map is open only while the four-bit map-enable field in control register 3 equals 1. A sticky lock bit in the same register freezes a scattered set of system-management bits, and the whole of address-range register 3, until reset. Every register is exported on flat output buses for the logic that consumes them. The I/O recovery field is also exported as a decoded clock count.

Top module: `cfg_regbank`

## Requirements
- R1: After reset every writable register reads 0x00, `rdata` is 0x00, `smm_locked` is 0 and `iort_clocks` is 1.
- R2: `idx_wr` latches `wdata` as the index. A data access issued in a later cycle without a fresh index reads 0xFF and writes nothing, because any data access consumes the index. A read updates `rdata` at the clock edge that samples `dat_rd`, and `rdata` holds between reads. `dat_wr` takes precedence over `dat_rd`.
- R3: The index map is: control registers 0 to 3 at 0xC0 to 0xC3; control register 4 at 0xE8; control register 5 at 0xE9; address-range register n at 0xC4+3n to 0xC6+3n, where the lowest index is bits 23:16 and the highest is bits 7:0; region register n at 0xDC+n; identification bytes at 0xFE and 0xFF. Every other index is unmapped.
- R4: Control registers 4 and 5, address-range registers 4 to 7 and all region registers are reachable only while bits 7:4 of control register 3 equal 1. All other mapped registers are reachable at any map-enable value.
- R5: A data access to an unmapped index, or to a gated index while it is closed, changes no state and reads 0xFF.
- R6: Unimplemented bits read as zero and ignore writes. The writable masks are 0x02, 0x96, 0x9C, 0xF7, 0x97 and 0x31 for control registers 0 to 5.
- R7: Writing 1 to bit 0 of control register 3 sets the lock. Once set, the lock ignores writes to bits 1, 2 and 7 of control register 1, to bit 1 of control register 3, to bit 0 of control register 3 itself, and to all three bytes of address-range register 3. Only reset clears the lock. The map-enable field stays writable.
- R8: Index 0xFE reads parameter `DEV_ID`. Index 0xFF reads `{DEV_STEP, DEV_REV}`. Writes to either index are ignored.
- R9: `iort_clocks` decodes bits 2:0 of control register 4. Values 0 to 6 give 1, 2, 4, 8, 16, 32 and 64. Value 7 gives 0, which means no delay.
- R10: `ccr_flat[8n+7:8n]` carries control register n. `arr_flat[24n+23:24n]` carries address-range register n. `rcr_flat[8n+7:8n]` carries region register n. `smm_locked` carries the lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Latch `wdata` as register index |
| dat_wr | input | 1 | Data write to the latched index |
| dat_rd | input | 1 | Data read from the latched index |
| wdata | input | 8 | Index or write data |
| rdata | output | 8 | Registered read data |
| ccr_flat | output | 48 | Control registers 0 to 5 |
| arr_flat | output | 192 | Address-range registers 0 to 7 |
| rcr_flat | output | 64 | Region registers 0 to 7 |
| iort_clocks | output | 7 | Decoded I/O recovery clock count |
| smm_locked | output | 1 | Lock bit state |

## Verification
A wrong map-enable value or a stale valid index shows up on the next data read: a register that should answer returns 0xFF, or the reverse. A frozen bit that moves under lock, or a rejected write that lands, appears on the flat output buses one clock after the write strobe. It also appears in `rdata` one clock after the following read. Decoder slips between neighbouring byte groups show up as data landing in the wrong 24-bit field of `arr_flat` in that same cycle.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

  localparam int NUM_CCR   = 6;
  localparam int NUM_ARR   = 8;
  localparam int ARR_BYTES = 3;
  localparam int NUM_RCR   = 8;
  localparam int ARR_W     = 8 * ARR_BYTES;
  localparam int IORT_W    = 7;
  localparam int SEL_W     = 5;

  localparam logic [7:0] IDX_CCR_LO  = 8'hC0;
  localparam logic [7:0] IDX_CCR_HI  = 8'hC3;
  localparam logic [7:0] IDX_CCR4    = 8'hE8;
  localparam logic [7:0] IDX_CCR5    = 8'hE9;
  localparam logic [7:0] IDX_ARR_LO  = 8'hC4;
  localparam logic [7:0] IDX_ARR_HI  = 8'hDB;
  localparam logic [7:0] IDX_RCR_LO  = 8'hDC;
  localparam logic [7:0] IDX_RCR_HI  = 8'hE3;
  localparam logic [7:0] IDX_DIR0    = 8'hFE;
  localparam logic [7:0] IDX_DIR1    = 8'hFF;

  // Bits of control register 1 frozen by the lock
  localparam logic [7:0] SMM1_BITS = 8'h86;
  // First address-range byte offset that is gated (register 4)
  localparam int ARR_GATE_OFS = 4 * ARR_BYTES;
  localparam int LOCKED_ARR   = 3;

  typedef enum logic [2:0] {
    RK_NONE, RK_CCR, RK_ARR, RK_RCR, RK_DIR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e          kind;
    logic [SEL_W-1:0]   sel;
    logic               gated;
  } reg_hit_t;

  function automatic logic [7:0] ccr_mask(input logic [2:0] n);
    case (n)
      3'd0:    return 8'h02;
      3'd1:    return 8'h96;
      3'd2:    return 8'h9C;
      3'd3:    return 8'hF7;
      3'd4:    return 8'h97;
      3'd5:    return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [IORT_W-1:0] iort_decode(input logic [2:0] v);
    if (v == 3'd7) return '0;
    return IORT_W'(1) << v;
  endfunction

  function automatic reg_hit_t decode_index(input logic [7:0] idx);
    reg_hit_t h;
    h.kind  = RK_NONE;
    h.sel   = '0;
    h.gated = 1'b0;
    if (idx >= IDX_CCR_LO && idx <= IDX_CCR_HI) begin
      h.kind = RK_CCR;
      h.sel  = SEL_W'(idx - IDX_CCR_LO);
    end else if (idx == IDX_CCR4 || idx == IDX_CCR5) begin
      h.kind  = RK_CCR;
      h.sel   = SEL_W'(idx - IDX_CCR4 + 8'd4);
      h.gated = 1'b1;
    end else if (idx >= IDX_ARR_LO && idx <= IDX_ARR_HI) begin
      h.kind  = RK_ARR;
      h.sel   = SEL_W'(idx - IDX_ARR_LO);
      h.gated = (int'(h.sel) >= ARR_GATE_OFS);
    end else if (idx >= IDX_RCR_LO && idx <= IDX_RCR_HI) begin
      h.kind  = RK_RCR;
      h.sel   = SEL_W'(idx - IDX_RCR_LO);
      h.gated = 1'b1;
    end else if (idx == IDX_DIR0 || idx == IDX_DIR1) begin
      h.kind = RK_DIR;
      h.sel  = SEL_W'(idx - IDX_DIR0);
    end
    return h;
  endfunction

  // Next value of a control register on a write, honouring masks and lock
  function automatic logic [7:0] next_ccr(input logic [2:0] n, input logic [7:0] cur,
                                          input logic [7:0] wd, input logic locked);
    logic [7:0] nv;
    nv = wd & ccr_mask(n);
    if (n == 3'd1 && locked)
      nv = (nv & ~SMM1_BITS) | (cur & SMM1_BITS);
    if (n == 3'd3) begin
      nv[0] = cur[0] | wd[0];
      if (locked) nv[1] = cur[1];
    end
    return nv;
  endfunction

endpackage

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
  import cfg_regbank_pkg::*;
(
  input  logic [7:0]       idx,
  output reg_kind_e        kind,
  output logic             gated,
  output logic [2:0]       ccr_sel,
  output logic [2:0]       rcr_sel,
  output logic             dir_sel,
  output logic [2:0]       arr_num,
  output logic [1:0]       arr_byte
);
  reg_hit_t hit;

  always_comb begin
    hit      = decode_index(idx);
    kind     = hit.kind;
    gated    = hit.gated;
    ccr_sel  = hit.sel[2:0];
    rcr_sel  = hit.sel[2:0];
    dir_sel  = hit.sel[0];
    arr_num  = 3'(hit.sel / SEL_W'(ARR_BYTES));
    arr_byte = 2'(hit.sel % SEL_W'(ARR_BYTES));
  end
endmodule

// File: rtl/cfg_ccr_bank.sv
module cfg_ccr_bank
  import cfg_regbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           sel,
  input  logic [7:0]           wdata,
  output logic [8*NUM_CCR-1:0] ccr_flat,
  output logic                 locked,
  output logic [3:0]           mapen
);
  logic [7:0] ccr_q [NUM_CCR];

  assign locked = ccr_q[3][0];
  assign mapen  = ccr_q[3][7:4];

  for (genvar n = 0; n < NUM_CCR; n++) begin : g_ccr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ccr_q[n] <= 8'h00;
      else if (wr_en && sel == 3'(n))
        ccr_q[n] <= next_ccr(3'(n), ccr_q[n], wdata, locked);
    end
    assign ccr_flat[8*n +: 8] = ccr_q[n];
  end

  // R7: lock is sticky until reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7: frozen system-management bits stay put under lock
  a_r7_smm_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({ccr_q[1][7], ccr_q[1][2:1], ccr_q[3][1]}));
endmodule

// File: rtl/cfg_region_bank.sv
module cfg_region_bank
  import cfg_regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arr_wr,
  input  logic                       rcr_wr,
  input  logic [2:0]                 arr_num,
  input  logic [1:0]                 arr_byte,
  input  logic [2:0]                 rcr_sel,
  input  logic [7:0]                 wdata,
  input  logic                       locked,
  output logic [ARR_W*NUM_ARR-1:0]   arr_flat,
  output logic [8*NUM_RCR-1:0]       rcr_flat,
  output logic [7:0]                 arr_rd,
  output logic [7:0]                 rcr_rd
);
  logic [ARR_W-1:0] arr_q [NUM_ARR];
  logic [7:0]       rcr_q [NUM_RCR];

  for (genvar n = 0; n < NUM_ARR; n++) begin : g_arr
    logic frozen;
    assign frozen = (n == LOCKED_ARR) && locked;
    for (genvar b = 0; b < ARR_BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          arr_q[n][ARR_W-8-8*b +: 8] <= 8'h00;
        else if (arr_wr && !frozen && arr_num == 3'(n) && arr_byte == 2'(b))
          arr_q[n][ARR_W-8-8*b +: 8] <= wdata;
      end
    end
    assign arr_flat[ARR_W*n +: ARR_W] = arr_q[n];
  end

  for (genvar n = 0; n < NUM_RCR; n++) begin : g_rcr
    always_ff @(posedge clk) begin
      if (!rst_n)
        rcr_q[n] <= 8'h00;
      else if (rcr_wr && rcr_sel == 3'(n))
        rcr_q[n] <= wdata;
    end
    assign rcr_flat[8*n +: 8] = rcr_q[n];
  end

  always_comb begin
    case (arr_byte)
      2'd0:    arr_rd = arr_q[arr_num][23:16];
      2'd1:    arr_rd = arr_q[arr_num][15:8];
      default: arr_rd = arr_q[arr_num][7:0];
    endcase
    rcr_rd = rcr_q[rcr_sel];
  end

  // R7: the locked address-range register cannot change
  a_r7_arr3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(arr_q[LOCKED_ARR]));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter logic [7:0] DEV_ID   = 8'h31,
  parameter logic [3:0] DEV_STEP = 4'h2,
  parameter logic [3:0] DEV_REV  = 4'h5
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_wr,
  input  logic                      dat_wr,
  input  logic                      dat_rd,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  output logic [8*NUM_CCR-1:0]      ccr_flat,
  output logic [ARR_W*NUM_ARR-1:0]  arr_flat,
  output logic [8*NUM_RCR-1:0]      rcr_flat,
  output logic [IORT_W-1:0]         iort_clocks,
  output logic                      smm_locked
);
  logic [7:0] idx_q;
  logic       idx_valid;
  reg_kind_e  kind;
  logic       gated, dir_sel;
  logic [2:0] ccr_sel, rcr_sel, arr_num;
  logic [1:0] arr_byte;
  logic [3:0] mapen;
  logic       map_open, access_ok, wr_go, rd_go;
  logic [7:0] arr_rd, rcr_rd, rd_val;

  cfg_index_decode u_dec (
    .idx(idx_q), .kind(kind), .gated(gated), .ccr_sel(ccr_sel),
    .rcr_sel(rcr_sel), .dir_sel(dir_sel), .arr_num(arr_num), .arr_byte(arr_byte)
  );

  assign map_open  = (mapen == 4'd1);
  assign access_ok = idx_valid && (kind != RK_NONE) && (!gated || map_open);
  assign wr_go     = dat_wr && access_ok;
  assign rd_go     = dat_rd && !dat_wr;

  cfg_ccr_bank u_ccr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go && kind == RK_CCR), .sel(ccr_sel),
    .wdata(wdata), .ccr_flat(ccr_flat), .locked(smm_locked), .mapen(mapen)
  );

  cfg_region_bank u_reg (
    .clk(clk), .rst_n(rst_n),
    .arr_wr(wr_go && kind == RK_ARR), .rcr_wr(wr_go && kind == RK_RCR),
    .arr_num(arr_num), .arr_byte(arr_byte), .rcr_sel(rcr_sel), .wdata(wdata),
    .locked(smm_locked), .arr_flat(arr_flat), .rcr_flat(rcr_flat),
    .arr_rd(arr_rd), .rcr_rd(rcr_rd)
  );

  assign iort_clocks = iort_decode(ccr_flat[8*4 +: 3]);

  always_comb begin
    rd_val = 8'hFF;
    if (access_ok) begin
      case (kind)
        RK_CCR:  rd_val = ccr_flat[8*ccr_sel +: 8];
        RK_ARR:  rd_val = arr_rd;
        RK_RCR:  rd_val = rcr_rd;
        RK_DIR:  rd_val = dir_sel ? {DEV_STEP, DEV_REV} : DEV_ID;
        default: rd_val = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= 8'h00;
      idx_valid <= 1'b0;
      rdata     <= 8'h00;
    end else begin
      if (idx_wr) begin
        idx_q     <= wdata;
        idx_valid <= 1'b1;
      end else if (dat_wr || dat_rd) begin
        idx_valid <= 1'b0;
      end
      if (rd_go) rdata <= rd_val;
    end
  end

  // R5: rejected writes leave every register unchanged
  a_r5_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !access_ok) |=> $stable({ccr_flat, arr_flat, rcr_flat}));

  // R5: rejected reads return all ones
  a_r5_reject_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !dat_wr && !access_ok) |=> (rdata == 8'hFF));

  // R2: a data access consumes the index
  a_r2_index_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_rd || dat_wr) && !idx_wr) |=> !idx_valid);

  // R2: rdata holds between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_go && $past(rst_n)) |=> $stable(rdata));
endmodule

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         idx_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
  logic [7:0]   wdata = 8'h00;
  logic [7:0]   rdata;
  logic [47:0]  ccr_flat;
  logic [191:0] arr_flat;
  logic [63:0]  rcr_flat;
  logic [6:0]   iort_clocks;
  logic         smm_locked;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  cfg_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .wdata(wdata), .rdata(rdata), .ccr_flat(ccr_flat), .arr_flat(arr_flat),
    .rcr_flat(rcr_flat), .iort_clocks(iort_clocks), .smm_locked(smm_locked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: the read sampled at a posedge shows on rdata before the next negedge
  always @(posedge clk) rd_seen <= rst_n && dat_rd && !dat_wr;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {24'd0, rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic set_idx(input logic [7:0] idx);
    @(negedge clk); idx_wr = 1'b1; wdata = idx;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] val);
    set_idx(idx);
    dat_wr = 1'b1; wdata = val;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic rd_raw(input logic [7:0] exp, input string tag);
    dat_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    set_idx(idx);
    rd_raw(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [6:0] iort_ref(input int v);
    int c = 1;
    for (int i = 0; i < v; i++) c = c * 2;
    return (v == 7) ? 7'd0 : 7'(c);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 rdata reset", {24'd0, rdata}, 32'h0);
    check("R1 lock reset", {31'd0, smm_locked}, 32'd0);
    check("R1 iort reset", {25'd0, iort_clocks}, 32'd1);
    for (int i = 0; i < 4; i++) rd(8'(8'hC0 + i), 8'h00, "R1 ccr reset");
    rd(8'hE8, 8'hFF, "R4 ccr4 gated at mapen 0");

    wr(8'hC1, 8'hFF); rd(8'hC1, 8'h96, "R6 ccr1 mask");
    check("R10 ccr1 bus", {24'd0, ccr_flat[15:8]}, 32'h96);
    wr(8'hC0, 8'hFF); rd(8'hC0, 8'h02, "R6 ccr0 mask");
    wr(8'hC2, 8'hFF); rd(8'hC2, 8'h9C, "R6 ccr2 mask");

    wr(8'hE8, 8'h05);
    wr(8'hC3, 8'h10); rd(8'hC3, 8'h10, "R4 open map");
    rd(8'hE8, 8'h00, "R5 gated write ignored");
    wr(8'hE8, 8'h05); rd(8'hE8, 8'h05, "R3 ccr4 readback");
    check("R9 iort 5", {25'd0, iort_clocks}, {25'd0, iort_ref(5)});
    wr(8'hE8, 8'hFF); rd(8'hE8, 8'h97, "R6 ccr4 mask");
    check("R9 iort 7", {25'd0, iort_clocks}, {25'd0, iort_ref(7)});
    wr(8'hE8, 8'h06);
    check("R9 iort 6", {25'd0, iort_clocks}, {25'd0, iort_ref(6)});
    wr(8'hE8, 8'h00);
    check("R9 iort 0", {25'd0, iort_clocks}, {25'd0, iort_ref(0)});
    wr(8'hE9, 8'hFF); rd(8'hE9, 8'h31, "R6 ccr5 mask");

    wr(8'hD3, 8'h12); wr(8'hD4, 8'h34); wr(8'hD5, 8'h56);
    check("R10 arr5 bus", {8'd0, arr_flat[5*24 +: 24]}, 32'h123456);
    rd(8'hD4, 8'h34, "R3 arr5 middle byte");
    wr(8'hC4, 8'hAB);
    check("R3 arr0 high byte", {8'd0, arr_flat[23:0]}, 32'hAB0000);
    wr(8'hDB, 8'hCD);
    check("R3 arr7 low byte", {8'd0, arr_flat[7*24 +: 24]}, 32'h0000CD);
    wr(8'hE0, 8'h3F); rd(8'hE0, 8'h3F, "R3 rcr4 readback");
    check("R10 rcr4 bus", {24'd0, rcr_flat[39:32]}, 32'h3F);

    rd(8'hFE, 8'h31, "R8 id byte");
    rd(8'hFF, 8'h25, "R8 step and revision");
    wr(8'hFE, 8'h00); rd(8'hFE, 8'h31, "R8 id write ignored");

    wr(8'h50, 8'hAA); rd(8'h50, 8'hFF, "R5 unmapped read");
    rd(8'hE4, 8'hFF, "R3 past last region register");
    rd(8'hC1, 8'h96, "R5 unmapped write no effect");

    set_idx(8'hC1);
    rd_raw(8'h96, "R2 first access uses index");
    rd_raw(8'hFF, "R2 index consumed");
    @(negedge clk); dat_wr = 1'b1; wdata = 8'h00;
    @(negedge clk); dat_wr = 1'b0;
    rd(8'hC1, 8'h96, "R2 write without index ignored");

    wr(8'hC3, 8'h20); rd(8'hE0, 8'hFF, "R4 mapen 2 closes map");
    rd(8'hC4, 8'hAB, "R4 ungated arr0 at mapen 2");
    wr(8'hE0, 8'h00);
    wr(8'hC3, 8'h10); rd(8'hE0, 8'h3F, "R4 write at mapen 2 ignored");

    wr(8'hCD, 8'h77);
    wr(8'hC3, 8'h13);
    check("R7 lock output", {31'd0, smm_locked}, 32'd1);
    rd(8'hC3, 8'h13, "R7 lock set");
    wr(8'hC1, 8'h00); rd(8'hC1, 8'h86, "R7 ccr1 smm bits frozen");
    wr(8'hC3, 8'h10); rd(8'hC3, 8'h13, "R7 lock and nmi frozen");
    wr(8'hCD, 8'h00); rd(8'hCD, 8'h77, "R7 arr3 frozen");
    wr(8'hCE, 8'h11);
    check("R7 arr3 bus frozen", {8'd0, arr_flat[3*24 +: 24]}, 32'h770000);
    wr(8'hC3, 8'h03); rd(8'hE0, 8'hFF, "R7 mapen still writable");

    do_reset();
    @(negedge clk);
    check("R1 lock cleared by reset", {31'd0, smm_locked}, 32'd0);
    rd(8'hC3, 8'h00, "R1 ccr3 after reset");
    wr(8'hC3, 8'h10); rd(8'hCD, 8'h00, "R1 arr3 after reset");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule